// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block holds a small set of instruction-count debug triggers. Each trigger owns one control word that software writes through a CSR port. The word carries a 14-bit remaining count and a set of privilege-enable bits. Each time the core retires an instruction, every trigger checks whether it is enabled for the current privilege level. The current level is the privilege code together with the virtualization flag. An enabled trigger with a non-zero count decrements that count by one. When the count steps from one to zero, the trigger emits a one-cycle breakpoint request on its own fire line and then stays idle until software loads a new count.

The retire strobe, the privilege inputs and the CSR port are plain control pins with no handshake. A write or a retire event takes effect at the clock edge where it is presented. The read port is combinational: it shows the selected trigger's control word, including the live remaining count.

Top module: `icnt_trigger`

## Requirements
- R1: After reset every trigger reads back with count 0 and all enables 0. The type field, bits XLEN-1:XLEN-4, reads 3. No fire line is high.
- R2: A write keeps only the count (bits 23:10) and the enables at bits 6 (U), 7 (S), 9 (M), 25 (VU) and 26 (VS). Every other bit reads 0, including bits 5:0, 8 and 24. The type field always reads 3 whatever was written.
- R3: Outside virtualization, with privilege codes U=0, S=1 and M=3, a retire while the enable bit 6+priv is set decrements a non-zero count by one.
- R4: While virtualized, only bit 25 (priv 0) and bit 26 (priv 1) can enable counting. The U/S/M bits have no effect there. Bits 25 and 26 have no effect outside virtualization.
- R5: A cycle with no retire, or a retire at a disabled level, leaves the count unchanged.
- R6: When a retire takes the count from 1 to 0, the trigger's fire line is high for exactly the one cycle after that edge. In that same cycle the count reads 0.
- R7: A trigger with count 0 never decrements and never fires on a retire.
- R8: A CSR write to a trigger wins over a decrement of that trigger at the same edge. The written count is stored unchanged and no fire is raised.
- R9: Triggers are independent. A write touches only the selected trigger, and each trigger decrements according to its own enables.
- R10: The read port returns the selected trigger's current remaining count after each decrement.
- R11: Privilege code 2 never enables counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 2 | Current privilege code (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Core runs virtualized |
| csr_we_i | input | 1 | Control-word write strobe |
| csr_sel_i | input | SEL_W | Trigger selected for write |
| csr_wdata_i | input | XLEN | Control-word write data |
| csr_rsel_i | input | SEL_W | Trigger selected for read |
| csr_rdata_o | output | XLEN | Control word of the read-selected trigger |
| fire_o | output | NUM_TRIG | Per-trigger one-cycle breakpoint request |

## Verification
The assertions assume that every input is driven to a known value at each clock edge. They also assume that the read select points at an existing trigger, so that the zero-count check during a fire cycle observes a real trigger. The virtualized-with-M-mode combination is treated as a don't-care. The stimulus respects all of this: it changes inputs only on falling edges, keeps both selects inside the trigger range, and pairs the virtualization flag only with privilege codes 0 and 1. It still drives code 2, to exercise the reserved level.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
  localparam int CNT_LO  = 10;
  localparam int CNT_W   = 14;
  localparam int EN_U    = 6;
  localparam int EN_S    = 7;
  localparam int EN_M    = 9;
  localparam int EN_VU   = 25;
  localparam int EN_VS   = 26;
  localparam logic [3:0] TYPE_CODE = 4'd3;

  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } prv_e;

  typedef struct packed {
    logic             vs;
    logic             vu;
    logic             m;
    logic             s;
    logic             u;
    logic [CNT_W-1:0] cnt;
  } icnt_cfg_t;
endpackage

// File: rtl/icnt_priv_match.sv
module icnt_priv_match
  import icnt_pkg::*;
(
  input  icnt_cfg_t  cfg_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  output logic       hit_o
);
  always_comb begin
    hit_o = 1'b0;
    if (virt_i) begin
      unique case (prv_e'(priv_i))
        PRV_U:   hit_o = cfg_i.vu;
        PRV_S:   hit_o = cfg_i.vs;
        default: hit_o = 1'b0;
      endcase
    end else begin
      unique case (prv_e'(priv_i))
        PRV_U:   hit_o = cfg_i.u;
        PRV_S:   hit_o = cfg_i.s;
        PRV_M:   hit_o = cfg_i.m;
        default: hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/icnt_slot.sv
module icnt_slot
  import icnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit_i,
  input  icnt_cfg_t wr_cfg_i,
  input  logic      retire_i,
  input  logic      mode_hit_i,
  output icnt_cfg_t cfg_o,
  output logic      fire_o
);
  icnt_cfg_t cfg_q;
  logic      fire_q;
  logic      step;

  // Decrement only when no write targets this slot and the count is live.
  assign step = retire_i && mode_hit_i && (cfg_q.cnt != '0) && !wr_hit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (wr_hit_i) begin
        cfg_q <= wr_cfg_i;
      end else if (step) begin
        cfg_q.cnt <= cfg_q.cnt - CNT_W'(1);
        fire_q    <= (cfg_q.cnt == CNT_W'(1));
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign fire_o = fire_q;
endmodule

// File: rtl/icnt_csr_view.sv
module icnt_csr_view
  import icnt_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int XLEN     = 32,
  localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  icnt_cfg_t [NUM_TRIG-1:0] cfg_all_i,
  input  logic [SEL_W-1:0]         rsel_i,
  output logic [XLEN-1:0]          rdata_o
);
  localparam int TYPE_LO = XLEN - 4;

  always_comb begin
    rdata_o = '0;
    rdata_o[TYPE_LO +: 4] = TYPE_CODE;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (rsel_i == SEL_W'(i)) begin
        rdata_o[CNT_LO +: CNT_W] = cfg_all_i[i].cnt;
        rdata_o[EN_U]  = cfg_all_i[i].u;
        rdata_o[EN_S]  = cfg_all_i[i].s;
        rdata_o[EN_M]  = cfg_all_i[i].m;
        rdata_o[EN_VU] = cfg_all_i[i].vu;
        rdata_o[EN_VS] = cfg_all_i[i].vs;
      end
    end
  end
endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
  import icnt_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int XLEN     = 32,
  localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                retire_i,
  input  logic [1:0]          priv_i,
  input  logic                virt_i,
  input  logic                csr_we_i,
  input  logic [SEL_W-1:0]    csr_sel_i,
  input  logic [XLEN-1:0]     csr_wdata_i,
  input  logic [SEL_W-1:0]    csr_rsel_i,
  output logic [XLEN-1:0]     csr_rdata_o,
  output logic [NUM_TRIG-1:0] fire_o
);
  icnt_cfg_t                wr_cfg;
  icnt_cfg_t [NUM_TRIG-1:0] cfg_all;

  // Legalize the written word: only enables and count survive.
  always_comb begin
    wr_cfg.cnt = csr_wdata_i[CNT_LO +: CNT_W];
    wr_cfg.u   = csr_wdata_i[EN_U];
    wr_cfg.s   = csr_wdata_i[EN_S];
    wr_cfg.m   = csr_wdata_i[EN_M];
    wr_cfg.vu  = csr_wdata_i[EN_VU];
    wr_cfg.vs  = csr_wdata_i[EN_VS];
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    logic mode_hit;
    logic wr_hit;

    assign wr_hit = csr_we_i && (csr_sel_i == SEL_W'(g));

    icnt_priv_match u_match (
      .cfg_i  (cfg_all[g]),
      .priv_i (priv_i),
      .virt_i (virt_i),
      .hit_o  (mode_hit)
    );

    icnt_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit_i   (wr_hit),
      .wr_cfg_i   (wr_cfg),
      .retire_i   (retire_i),
      .mode_hit_i (mode_hit),
      .cfg_o      (cfg_all[g]),
      .fire_o     (fire_o[g])
    );
  end

  icnt_csr_view #(
    .NUM_TRIG (NUM_TRIG),
    .XLEN     (XLEN)
  ) u_view (
    .cfg_all_i (cfg_all),
    .rsel_i    (csr_rsel_i),
    .rdata_o   (csr_rdata_o)
  );
endmodule

// File: rtl/icnt_trigger_chk.sv
module icnt_trigger_chk #(
  parameter int NUM_TRIG = 2,
  parameter int XLEN     = 32,
  parameter int SEL_W    = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                retire_i,
  input logic [1:0]          priv_i,
  input logic                virt_i,
  input logic                csr_we_i,
  input logic [SEL_W-1:0]    csr_sel_i,
  input logic [XLEN-1:0]     csr_wdata_i,
  input logic [SEL_W-1:0]    csr_rsel_i,
  input logic [XLEN-1:0]     csr_rdata_o,
  input logic [NUM_TRIG-1:0] fire_o
);
  // R2: type field is fixed.
  p_type_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata_o[XLEN-1 -: 4] == 4'd3);

  // R5: no retire means nothing can fire at the next edge.
  p_no_retire_no_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_i |=> (fire_o == '0));

  // R11: reserved privilege code never counts.
  p_reserved_priv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && priv_i == 2'd2) |=> (fire_o == '0));

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_chk
    // R6: fire is a single-cycle pulse.
    p_fire_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o[g] |=> !fire_o[g]);

    // R6: count reads zero while the trigger fires.
    p_fire_zero_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o[g] && csr_rsel_i == SEL_W'(g)) |-> (csr_rdata_o[23:10] == '0));

    // R8: a write to the trigger suppresses its fire.
    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we_i && csr_sel_i == SEL_W'(g)) |=> !fire_o[g]);
  end
endmodule

bind icnt_trigger icnt_trigger_chk #(
  .NUM_TRIG (NUM_TRIG),
  .XLEN     (XLEN),
  .SEL_W    (SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .retire_i    (retire_i),
  .priv_i      (priv_i),
  .virt_i      (virt_i),
  .csr_we_i    (csr_we_i),
  .csr_sel_i   (csr_sel_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rsel_i  (csr_rsel_i),
  .csr_rdata_o (csr_rdata_o),
  .fire_o      (fire_o)
);

// File: tb/icnt_trigger_bench.sv
`timescale 1ns/10ps
module icnt_trigger_bench;
  localparam int NT = 2;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          retire = 1'b0;
  logic [1:0]    priv = 2'd0;
  logic          virt = 1'b0;
  logic          we = 1'b0;
  logic [0:0]    wsel = '0;
  logic [XL-1:0] wdata = '0;
  logic [0:0]    rsel = '0;
  logic [XL-1:0] rdata;
  logic [NT-1:0] fire;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  icnt_trigger #(.NUM_TRIG(NT), .XLEN(XL)) u_icnt_trigger (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .priv_i(priv), .virt_i(virt),
    .csr_we_i(we), .csr_sel_i(wsel), .csr_wdata_i(wdata),
    .csr_rsel_i(rsel), .csr_rdata_o(rdata), .fire_o(fire)
  );

  typedef struct {
    string       tag;
    bit          is_fire;
    int          sel;
    logic [31:0] exp;
  } exp_t;

  exp_t q[$];

  function automatic logic [31:0] ctl(bit u, bit s, bit m, bit vu, bit vs, int cnt);
    logic [31:0] v;
    v = 32'h3000_0000;
    v[6] = u; v[7] = s; v[9] = m; v[25] = vu; v[26] = vs;
    v[23:10] = 14'(cnt);
    return v;
  endfunction

  // Driver: present inputs at a falling edge, return just after the rising edge.
  task automatic drv(bit ret, logic [1:0] pr, bit v, bit w, int ws, logic [31:0] wd);
    @(negedge clk);
    retire = ret; priv = pr; virt = v; we = w; wsel = 1'(ws); wdata = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic exp_rd(string tag, int sel, logic [31:0] val);
    exp_t e;
    e.tag = tag; e.is_fire = 1'b0; e.sel = sel; e.exp = val;
    q.push_back(e);
  endtask

  task automatic exp_fire(string tag, logic [NT-1:0] val);
    exp_t e;
    e.tag = tag; e.is_fire = 1'b1; e.sel = 0; e.exp = 32'(val);
    q.push_back(e);
  endtask

  // Monitor: pops expectations after each rising edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic [31:0] act;
        e = q.pop_front();
        if (!e.is_fire) rsel = 1'(e.sel);
        #0.1;
        act = e.is_fire ? 32'(fire) : rdata;
        n_chk++;
        if (act !== e.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", e.tag, act, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    drv(0, 0, 0, 0, 0, 0);
    exp_rd("R1", 0, 32'h3000_0000); exp_rd("R1", 1, 32'h3000_0000); exp_fire("R1", 2'b00);

    // R2 legalization
    drv(0, 0, 0, 1, 0, 32'hFFFF_FFFF);
    exp_rd("R2", 0, ctl(1,1,1,1,1,14'h3FFF));
    drv(0, 0, 0, 1, 1, 32'hF100_013F);
    exp_rd("R2", 1, 32'h3000_0000);

    // R3/R5/R4/R11/R10/R6/R7 on trigger 0 with U enable
    drv(0, 0, 0, 1, 0, ctl(1,0,0,0,0,3));
    drv(1, 0, 0, 0, 0, 0); exp_rd("R3", 0, ctl(1,0,0,0,0,2));
    drv(1, 1, 0, 0, 0, 0); exp_rd("R5", 0, ctl(1,0,0,0,0,2));
    drv(1, 3, 0, 0, 0, 0); exp_rd("R5", 0, ctl(1,0,0,0,0,2));
    drv(1, 2, 0, 0, 0, 0); exp_rd("R11", 0, ctl(1,0,0,0,0,2)); exp_fire("R11", 2'b00);
    drv(1, 0, 1, 0, 0, 0); exp_rd("R4", 0, ctl(1,0,0,0,0,2));
    drv(0, 0, 0, 0, 0, 0); exp_rd("R5", 0, ctl(1,0,0,0,0,2));
    drv(1, 0, 0, 0, 0, 0); exp_rd("R10", 0, ctl(1,0,0,0,0,1)); exp_fire("R6", 2'b00);
    drv(1, 0, 0, 0, 0, 0); exp_rd("R6", 0, ctl(1,0,0,0,0,0)); exp_fire("R6", 2'b01);
    drv(0, 0, 0, 0, 0, 0); exp_fire("R6", 2'b00);
    drv(1, 0, 0, 0, 0, 0); exp_rd("R7", 0, ctl(1,0,0,0,0,0)); exp_fire("R7", 2'b00);

    // R4/R9 virtualized VS on trigger 1, M on trigger 0
    drv(0, 0, 0, 1, 0, ctl(0,0,1,0,0,2));
    drv(0, 0, 0, 1, 1, ctl(0,0,0,0,1,1));
    exp_rd("R9", 0, ctl(0,0,1,0,0,2));
    drv(1, 1, 1, 0, 0, 0);
    exp_fire("R4", 2'b10); exp_rd("R9", 0, ctl(0,0,1,0,0,2)); exp_rd("R4", 1, ctl(0,0,0,0,1,0));
    drv(1, 3, 0, 0, 0, 0); exp_rd("R3", 0, ctl(0,0,1,0,0,1)); exp_fire("R4", 2'b00);

    // R8 write wins over decrement
    drv(1, 3, 0, 1, 0, ctl(0,0,1,0,0,5));
    exp_rd("R8", 0, ctl(0,0,1,0,0,5));
    drv(1, 3, 0, 1, 0, ctl(0,0,1,0,0,1));
    exp_fire("R8", 2'b00); exp_rd("R8", 0, ctl(0,0,1,0,0,1));
    drv(1, 3, 0, 0, 0, 0); exp_fire("R6", 2'b01);

    // R3 S enable and R4 VU enable on trigger 1; R9 trigger 0 untouched
    drv(0, 0, 0, 1, 1, ctl(0,1,0,0,0,2));
    drv(1, 1, 0, 0, 0, 0); exp_rd("R3", 1, ctl(0,1,0,0,0,1));
    drv(1, 1, 1, 0, 0, 0); exp_rd("R4", 1, ctl(0,1,0,0,0,1));
    drv(0, 0, 0, 1, 1, ctl(0,0,0,1,0,1));
    drv(1, 0, 0, 0, 0, 0); exp_rd("R4", 1, ctl(0,0,0,1,0,1));
    drv(1, 0, 1, 0, 0, 0); exp_fire("R4", 2'b10); exp_rd("R9", 0, ctl(0,0,1,0,0,0));

    drv(0, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule